// File: doc/BRIEF.md
# Interrupt Status and Enable Unit for a Bus Master

This unit collects eight interrupt causes from a serial bus master and keeps each one in a sticky status bit. Software reads the status word over a simple register port and clears bits by writing ones to them. An enable word, also reachable over the port, selects which status bits may drive the single interrupt line.

Two kinds of cause share the status word. Event causes arrive as one-cycle pulses: a packet finishes, the whole packet list finishes, the transmit queue overflows, the receive queue underflows, a target fails to acknowledge, or arbitration is lost. Request causes are levels that stay high while a data queue wants service, one for transmit and one for receive. Both kinds set their bit in the same way. A request that is still high after its bit is cleared sets the bit again.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset, the status word, the enable word and the interrupt line are all zero.
- R2: The status bit positions are fixed: bit 7 packet done, bit 6 all packets done, bit 5 transmit overflow, bit 4 receive underflow, bit 3 no-acknowledge, bit 2 arbitration lost, bit 1 transmit data request, bit 0 receive data request. A cause that is high in cycle N sets its bit, and the bit reads 1 from cycle N+1.
- R3: A status bit stays set, once set, until software clears it. A cause going low does not clear it.
- R4: A write to the status address (address 1) clears each bit whose write-data bit is 1. Bits written with 0 do not change. Writing 0xFF clears every bit whose cause is low.
- R5: When a cause is high in the same cycle as a write that clears its bit, the bit stays set.
- R6: A request cause that is still high sets its bit again in the cycle after a clear, so the bit never reads 0.
- R7: A write to the enable address (address 2) replaces the enable word. A 1 in the enable word lets that status bit reach the interrupt line.
- R8: The interrupt line is registered. In every cycle it equals the OR over all eight bits of (status AND enable) as they stood in the previous cycle.
- R9: A read returns the status word at address 1 and the enable word at address 2, combinationally in the same cycle. Any other address reads 0, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_i | input | 8 | Cause inputs: pulses for bits 7..2, levels for bits 1..0 |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 2 | Register address: 1 for status, 2 for enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt line |

## Verification
The properties assume that a bit can be set only through its cause input, and that it can be cleared only by a status write naming that bit while the cause is low. Because of this, the cause and write inputs may be driven freely, with no constraint on how they interleave. The stimulus draws random causes, addresses and data in every cycle, including writes that collide with causes. It also holds the request inputs high for long stretches so that the re-set path is exercised. Directed steps cover reset, clearing everything, and a clear that collides with a cause.

// File: rtl/irq_stat_unit.sv
module irq_stat_unit #(
  parameter int NSRC = 8,
  parameter int AW   = 2,
  parameter logic [AW-1:0] STAT_ADDR = AW'(1),
  parameter logic [AW-1:0] ENAB_ADDR = AW'(2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cause_i,
  input  logic            reg_wr_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [NSRC-1:0] reg_wdata_i,
  output logic [NSRC-1:0] reg_rdata_o,
  output logic            irq_o
);

  logic [NSRC-1:0] stat_q, enab_q, clr;
  logic            stat_sel, enab_sel;

  assign stat_sel = reg_wr_i && (reg_addr_i == STAT_ADDR);
  assign enab_sel = reg_wr_i && (reg_addr_i == ENAB_ADDR);
  assign clr      = stat_sel ? reg_wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | cause_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        enab_q <= '0;
    else if (enab_sel) enab_q <= reg_wdata_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(stat_q & enab_q);

  always_comb
    case (reg_addr_i)
      STAT_ADDR: reg_rdata_o = stat_q;
      ENAB_ADDR: reg_rdata_o = enab_q;
      default:   reg_rdata_o = '0;
    endcase

endmodule

module irq_stat_unit_chk #(
  parameter int NSRC = 8,
  parameter int AW   = 2,
  parameter logic [AW-1:0] STAT_ADDR = AW'(1),
  parameter logic [AW-1:0] ENAB_ADDR = AW'(2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] cause_i,
  input logic            reg_wr_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [NSRC-1:0] reg_wdata_i,
  input logic [NSRC-1:0] stat_q,
  input logic [NSRC-1:0] enab_q,
  input logic            irq_o
);
  // R2
  cause_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(cause_i)) == $past(cause_i)));
  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == STAT_ADDR) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(cause_i)) == '0));
  // R7
  enab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == ENAB_ADDR) |=> $stable(enab_q));
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(stat_q) & $past(enab_q))));
endmodule

bind irq_stat_unit irq_stat_unit_chk #(
  .NSRC(NSRC), .AW(AW), .STAT_ADDR(STAT_ADDR), .ENAB_ADDR(ENAB_ADDR)
) u_chk (.*);

// File: tb/sim_irq_stat_unit.sv
module sim_irq_stat_unit;
  logic clk = 0, rst_n = 0;
  logic [7:0] cause = 0, wdata = 0;
  logic       wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] rdata;
  logic       irq;
  int checks = 0, fails = 0;
  logic [7:0] m_stat = 0, m_enab = 0;
  logic       m_irq = 0;
  logic       done = 0;

  always #5 clk = ~clk;

  irq_stat_unit u0 (.clk(clk), .rst_n(rst_n), .cause_i(cause), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic [7:0] nxt_stat(logic [7:0] s, logic [7:0] c,
                                          logic w, logic [1:0] a, logic [7:0] d);
    return (s & ~((w && a == 2'd1) ? d : 8'h00)) | c;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [7:0] c, logic w, logic [1:0] a, logic [7:0] d);
    cause = c; wr = w; addr = a; wdata = d;
    @(posedge clk);
    m_irq  = |(m_stat & m_enab);
    m_stat = nxt_stat(m_stat, c, w, a, d);
    if (w && a == 2'd2) m_enab = d;
    #1;
    cause = 0; wr = 0;
  endtask

  task automatic rd(string req, logic [1:0] a);
    addr = a; #1;
    chk(req, rdata, a == 2'd1 ? m_stat : a == 2'd2 ? m_enab : 8'h00);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    rd("R1", 2'd1); rd("R1", 2'd2); chk("R1", {7'd0, irq}, 8'd0);
    rst_n = 1; #10;
    step(8'h80, 0, 0, 0); rd("R2 bit7", 2'd1);
    step(8'h01, 0, 0, 0); rd("R2 bit0", 2'd1);
    step(8'h00, 0, 0, 0); rd("R3", 2'd1);
    step(8'h00, 1, 2'd1, 8'h80); rd("R4 partial", 2'd1);
    step(8'h08, 1, 2'd1, 8'h08); rd("R5", 2'd1);
    step(8'h02, 1, 2'd1, 8'hFF); rd("R6", 2'd1);
    step(8'h00, 1, 2'd1, 8'hFF); rd("R4 all", 2'd1);
    step(8'h00, 1, 2'd0, 8'hFF); rd("R9 other", 2'd0); rd("R9 unchanged", 2'd2);
    step(8'h00, 1, 2'd2, 8'h04); rd("R7", 2'd2);
    step(8'h00, 0, 0, 0); chk("R8 enabled idle", {7'd0, irq}, {7'd0, m_irq});
    step(8'h04, 0, 0, 0); #3; chk("R8", {7'd0, irq}, {7'd0, m_irq});
    step(8'h00, 0, 0, 0); #3; chk("R8 raise", {7'd0, irq}, 8'd1);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] c;
      c = {$urandom_range(0, 7) == 0 ? 6'($urandom) : 6'd0,
           (i % 200 < 100) ? 2'b11 : 2'($urandom)};
      step(c, $urandom_range(0, 2) == 0, 2'($urandom), 8'($urandom));
      #2;
      chk("R8 random", {7'd0, irq}, {7'd0, m_irq});
      rd("R9 random", 2'($urandom));
      rd("R3 random", 2'd1);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule